// File: doc/BRIEF.md
# Hierarchical Device Bin Tally

This block keeps running totals of tested devices sorted into a three-level tree of bins. Each device result arrives as a leaf-bin code with a one-cycle strobe. The block then adds one to the counter of that leaf. It also adds one to the counter of the leaf's hard-bin parent and to the counter of the primary pass or fail bin above that. The parent relationships are fixed when the block is built.

The hard-bin number is the sort category sent to the device handler. It is returned one cycle after each accepted result. Codes that are not in the tree are dropped and raise a one-cycle error pulse. Any counter can be read at any time through a combinational read port, addressed by level and bin number. A clear input sets every counter to zero.

The tree is:

| Primary bin | Hard bin | Leaf codes |
|---|---|---|
| pass (0) | 1 | 1 |
| fail (1) | 2 | 2, 3 |
| fail (1) | 3 | 4, 6, 7 |
| fail (1) | 4 | 8, 9 |

The block has no state machine. An accepted result is handled in the cycle it arrives, so the block has only two conditions: a result is accepted, or it is dropped because of a clear or an unknown code.

Top module: `bin_tally`

## Requirements
- R1: After reset, every counter reads zero and `sort_vld` and `bad_code` are low.
- R2: A strobe with a defined leaf code increments that leaf's counter by one. The new value is readable in the cycle after the strobe. The defined leaf codes are 1, 2, 3, 4, 6, 7, 8 and 9.
- R3: The same strobe increments the leaf's hard-bin counter:
  - leaf 1 → hard 1
  - leaves 2 and 3 → hard 2
  - leaves 4, 6 and 7 → hard 3
  - leaves 8 and 9 → hard 4
- R4: The same strobe increments exactly one primary counter: pass (0) when the hard bin is 1, and fail (1) for hard bins 2 to 4. An accepted result therefore changes exactly three counters.
- R5: In the cycle after an accepted strobe, `sort_vld` is high for that one cycle and `sort_bin` equals the leaf's hard-bin number.
- R6: A strobe with leaf code 0, 5 or 10 to 15 changes no counter and does not raise `sort_vld`. Instead it pulses `bad_code` in the next cycle.
- R7: Each counter is `CNT_W` bits wide (16 by default). It stops at its maximum value (65535 by default) and does not wrap.
- R8: `clr` sets all counters to zero in the next cycle. A strobe in the same cycle as `clr` is discarded and raises neither `sort_vld` nor `bad_code`.
- R9: The read port is combinational. `rd_lvl` selects the level: 0 for primary, 1 for hard, 2 for leaf. `rd_num` selects the bin number within that level. An address with no bin behind it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all counters |
| ev_valid | input | 1 | Device result strobe |
| ev_code | input | 4 | Leaf-bin code of the result |
| rd_lvl | input | 2 | Read level (0 primary, 1 hard, 2 leaf) |
| rd_num | input | 4 | Bin number within the read level |
| rd_data | output | CNT_W | Selected counter value |
| sort_vld | output | 1 | Accepted result reported |
| sort_bin | output | 3 | Hard-bin number of the reported result |
| bad_code | output | 1 | Undefined leaf code seen |

## Verification
Every counter update and both status pulses come from registers on the edge that samples the strobe, so they are due exactly one cycle after it. The bench drives each strobe on a falling edge and removes it on the next falling edge. It then checks `sort_vld`, `sort_bin` and `bad_code` at that point, which is half a cycle after the capturing edge. Counter values are compared by sweeping every read address while no strobe is active. The read port is combinational, so each address is sampled a short delay after it is set.

// File: rtl/bin_tally_pkg.sv
package bin_tally_pkg;

    localparam int NUM_PRIM  = 2;
    localparam int NUM_HARD  = 4;
    localparam int NUM_SOFT  = 8;
    localparam int NUM_BINS  = NUM_PRIM + NUM_HARD + NUM_SOFT;
    localparam int HARD_BASE = NUM_PRIM;
    localparam int SOFT_BASE = NUM_PRIM + NUM_HARD;

    typedef enum logic [1:0] {
        LVL_PRIM = 2'd0,
        LVL_HARD = 2'd1,
        LVL_SOFT = 2'd2
    } bin_level_e;

    typedef struct packed {
        logic       known;
        logic       fail;
        logic [2:0] hard;
        logic [2:0] slot;
    } leaf_info_t;

    // Fixed tree: leaf code -> hard parent and dense leaf slot
    function automatic leaf_info_t decode_leaf(input logic [3:0] code);
        leaf_info_t r;
        r       = '0;
        r.known = 1'b1;
        case (code)
            4'd1:    begin r.hard = 3'd1; r.slot = 3'd0; end
            4'd2:    begin r.hard = 3'd2; r.slot = 3'd1; end
            4'd3:    begin r.hard = 3'd2; r.slot = 3'd2; end
            4'd4:    begin r.hard = 3'd3; r.slot = 3'd3; end
            4'd6:    begin r.hard = 3'd3; r.slot = 3'd4; end
            4'd7:    begin r.hard = 3'd3; r.slot = 3'd5; end
            4'd8:    begin r.hard = 3'd4; r.slot = 3'd6; end
            4'd9:    begin r.hard = 3'd4; r.slot = 3'd7; end
            default: r.known = 1'b0;
        endcase
        r.fail = (r.hard != 3'd1);
        return r;
    endfunction

endpackage

// File: rtl/bin_leaf_decode.sv
module bin_leaf_decode
    import bin_tally_pkg::*;
(
    input  logic                ev_valid,
    input  logic                clr,
    input  logic [3:0]          ev_code,
    output logic [NUM_BINS-1:0] inc_vec,
    output logic                known,
    output logic [2:0]          hard
);
    leaf_info_t info;

    always_comb begin
        info    = decode_leaf(ev_code);
        known   = info.known;
        hard    = info.hard;
        inc_vec = '0;
        if (ev_valid && !clr && info.known) begin
            inc_vec[info.fail ? 1 : 0]                 = 1'b1;
            inc_vec[HARD_BASE + int'(info.hard) - 1]   = 1'b1;
            inc_vec[SOFT_BASE + int'(info.slot)]       = 1'b1;
        end
    end
endmodule

// File: rtl/bin_sat_counter.sv
module bin_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R2
endmodule

// File: rtl/bin_read_mux.sv
module bin_read_mux
    import bin_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [NUM_BINS-1:0][CNT_W-1:0] cnt,
    input  logic [1:0]                     rd_lvl,
    input  logic [3:0]                     rd_num,
    output logic [CNT_W-1:0]               rd_data
);
    leaf_info_t rinfo;
    int         num_i;

    always_comb begin
        rinfo   = decode_leaf(rd_num);
        num_i   = int'(rd_num);
        rd_data = '0;
        case (bin_level_e'(rd_lvl))
            LVL_PRIM: if (num_i < NUM_PRIM) rd_data = cnt[num_i];
            LVL_HARD: if (num_i >= 1 && num_i <= NUM_HARD)
                          rd_data = cnt[HARD_BASE + num_i - 1];
            LVL_SOFT: if (rinfo.known) rd_data = cnt[SOFT_BASE + int'(rinfo.slot)];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bin_tally.sv
module bin_tally
    import bin_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_valid,
    input  logic [3:0]       ev_code,
    input  logic [1:0]       rd_lvl,
    input  logic [3:0]       rd_num,
    output logic [CNT_W-1:0] rd_data,
    output logic             sort_vld,
    output logic [2:0]       sort_bin,
    output logic             bad_code
);
    logic [NUM_BINS-1:0]            inc_vec;
    logic [NUM_BINS-1:0][CNT_W-1:0] cnt;
    logic                           dec_known;
    logic [2:0]                     dec_hard;
    logic                           accept;

    bin_leaf_decode u_dec (
        .ev_valid (ev_valid),
        .clr      (clr),
        .ev_code  (ev_code),
        .inc_vec  (inc_vec),
        .known    (dec_known),
        .hard     (dec_hard)
    );

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_cnt
        bin_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_vec[g]),
            .cnt   (cnt[g])
        );
    end

    bin_read_mux #(.CNT_W(CNT_W)) u_rd (
        .cnt     (cnt),
        .rd_lvl  (rd_lvl),
        .rd_num  (rd_num),
        .rd_data (rd_data)
    );

    assign accept = ev_valid && !clr && dec_known;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sort_vld <= 1'b0;
            sort_bin <= '0;
            bad_code <= 1'b0;
        end else begin
            sort_vld <= accept;
            sort_bin <= accept ? dec_hard : 3'd0;
            bad_code <= ev_valid && !clr && !dec_known;
        end
    end

    AST_CHAIN_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(inc_vec) == 3)); // R4
    AST_ONE_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_vec[1:0])); // R4
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !dec_known) |-> (inc_vec == '0)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8
    AST_SORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sort_vld |-> (sort_bin >= 3'd1 && sort_bin <= 3'd4 && !bad_code)); // R5
endmodule

// File: tb/sim_bin_tally.sv
`timescale 1ns/1ps
module sim_bin_tally;
    localparam int W   = 16;
    localparam int MAX = 65535;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         ev_valid = 1'b0;
    logic [3:0]   ev_code = '0;
    logic [1:0]   rd_lvl = '0;
    logic [3:0]   rd_num = '0;
    logic [W-1:0] rd_data;
    logic         sort_vld;
    logic [2:0]   sort_bin;
    logic         bad_code;

    int n_chk = 0;
    int n_bad = 0;
    int m_prim [2];
    int m_hard [5];
    int m_soft [16];

    always #2.5 clk = ~clk;

    bin_tally #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ev_valid(ev_valid), .ev_code(ev_code),
        .rd_lvl(rd_lvl), .rd_num(rd_num), .rd_data(rd_data),
        .sort_vld(sort_vld), .sort_bin(sort_bin), .bad_code(bad_code)
    );

    function automatic bit is_leaf(input int c);
        return (c == 1 || c == 2 || c == 3 || c == 4 || c == 6 || c == 7 || c == 8 || c == 9);
    endfunction

    function automatic int parent_hard(input int c);
        if (c == 1) return 1;
        if (c == 2 || c == 3) return 2;
        if (c == 4 || c == 6 || c == 7) return 3;
        return 4;
    endfunction

    function automatic int exp_read(input int lvl, input int num);
        if (lvl == 0 && num < 2) return m_prim[num];
        if (lvl == 1 && num >= 1 && num <= 4) return m_hard[num];
        if (lvl == 2 && is_leaf(num)) return m_soft[num];
        return 0;
    endfunction

    function automatic int sat(input int v);
        return (v > MAX) ? MAX : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2; i++) m_prim[i] = 0;
        for (int i = 0; i < 5; i++) m_hard[i] = 0;
        for (int i = 0; i < 16; i++) m_soft[i] = 0;
    endtask

    task automatic model_add(input int c, input int n);
        int h;
        h = parent_hard(c);
        m_soft[c] = sat(m_soft[c] + n);
        m_hard[h] = sat(m_hard[h] + n);
        m_prim[(h == 1) ? 0 : 1] = sat(m_prim[(h == 1) ? 0 : 1] + n);
    endtask

    task automatic check_reads();
        for (int l = 0; l < 3; l++) begin
            for (int n = 0; n < 16; n++) begin
                int e;
                string tag;
                rd_lvl = 2'(l);
                rd_num = 4'(n);
                #0.2;
                e = exp_read(l, n);
                if ((l == 0 && n >= 2) || (l == 1 && (n == 0 || n > 4)) || (l == 2 && !is_leaf(n)))
                    tag = "R9 unmapped";
                else if (l == 0) tag = "R4 primary";
                else if (l == 1) tag = "R3 hard";
                else tag = "R2 leaf";
                check(int'(rd_data) == e, tag, int'(rd_data), e);
            end
        end
        rd_lvl = 2'd3;
        rd_num = 4'd0;
        #0.2;
        check(rd_data == '0, "R9 level3", int'(rd_data), 0);
    endtask

    task automatic send(input int c, input bit with_clr);
        bit acc;
        bit bad;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code  = 4'(c);
        clr      = with_clr;
        @(negedge clk);
        ev_valid = 1'b0;
        clr      = 1'b0;
        acc = !with_clr && is_leaf(c);
        bad = !with_clr && !is_leaf(c);
        check(sort_vld == acc, "R5 sort_vld", int'(sort_vld), int'(acc));
        if (acc) check(int'(sort_bin) == parent_hard(c), "R5 sort_bin", int'(sort_bin), parent_hard(c));
        check(bad_code == bad, "R6 bad_code", int'(bad_code), int'(bad));
        if (with_clr) model_clear();
        else if (acc) model_add(c, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sort_vld == 1'b0, "R1 sort_vld", int'(sort_vld), 0);
        check(bad_code == 1'b0, "R1 bad_code", int'(bad_code), 0);
        check_reads();

        // directed: every leaf once, then every undefined code (R6)
        for (int c = 0; c < 16; c++) send(c, 1'b0);
        check_reads();
        // R8 clear with simultaneous event
        send(3, 1'b1);
        check_reads();
        // R8 plain clear
        send(1, 1'b0);
        send(7, 1'b0);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_clear();
        check(sort_vld == 1'b0, "R8 no sort", int'(sort_vld), 0);
        check_reads();

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) send(int'($urandom % 16), 1'b1);
            else if (r < 70) send(int'($urandom % 10), 1'b0);
            else send(int'($urandom % 16), 1'b0);
            if (i % 250 == 249) check_reads();
        end
        check_reads();

        // R7 saturation: back-to-back strobes on leaf 9
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code  = 4'd9;
        repeat (65600) @(negedge clk);
        ev_valid = 1'b0;
        model_add(9, 65600);
        check(sort_vld == 1'b1 && sort_bin == 3'd4, "R7 sort during burst", int'(sort_bin), 4);
        rd_lvl = 2'd2; rd_num = 4'd9; #0.2;
        check(int'(rd_data) == MAX, "R7 leaf saturated", int'(rd_data), MAX);
        send(9, 1'b0);
        check_reads();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule